// File: doc/BRIEF.md
# Subroutine Call Handshake Unit

This block lets a hardware datapath hand a piece of work to an external function engine and then wait for the answer. The datapath has several call slots. Each slot offers a trigger bit, a target identifier and six 32-bit argument words. When the unit is idle and one or more triggers are high, it picks the lowest-numbered triggered slot. It copies that slot's arguments and target identifier into output registers and raises a start request toward the engine.

The start request stays high until the engine pulses its end input. While the end input is high, the unit reports completion on the pending slot's own done bit. On that clock edge it stores the engine's 32-bit return value, drops the start request and returns to idle. Only one call is in flight at a time, and triggers that arrive while a call is pending are ignored. When only one target exists, the identifier output is a single bit tied to zero.

Top module: `callout_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the argument outputs, the target output, the start output, the result output and all pending state are zero after that edge.
- R2: When no call is pending and at least one trigger is high at a rising edge, `start_o` is 1 after that edge and `arg_o` holds the six words of the chosen slot. Word k sits at bits [32k+31:32k], and slot s's word k sits at bits [192s+32k+31:192s+32k] of `call_args_i`.
- R3: When several triggers are high together, the slot with the lowest index is launched.
- R4: `target_o` takes the launched slot's identifier, which is the ID_W-bit field at [ID_W·s+ID_W-1:ID_W·s] of `call_target_i`, where ID_W is ceil(log2(NUM_TARGETS)). With NUM_TARGETS = 1 the field is one bit and `target_o` is always 0.
- R5: `slot_done_o[s]` is 1 exactly when slot s is pending and `callee_end_i` is 1, in the same cycle. At most one done bit is ever set.
- R6: `start_o` stays 1 from launch until the edge at which `callee_end_i` is seen high. It is 0 after that edge.
- R7: While a call is pending, triggers have no effect: `arg_o`, `target_o` and the pending slot are unchanged. This also holds in the completion cycle.
- R8: `result_o` takes `callee_result_i` at the edge where a completion is seen. It holds its value otherwise, including when `callee_end_i` pulses while no call is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_trig_i | input | NUM_SLOTS | Per-slot call trigger |
| call_target_i | input | NUM_SLOTS*ID_W | Per-slot target identifier fields |
| call_args_i | input | NUM_SLOTS*192 | Per-slot six 32-bit argument words |
| callee_end_i | input | 1 | End pulse from the function engine |
| callee_result_i | input | 32 | Return value from the function engine |
| arg_o | output | 192 | Latched six argument words |
| target_o | output | ID_W | Latched target identifier |
| start_o | output | 1 | Start request to the function engine |
| slot_done_o | output | NUM_SLOTS | Per-slot completion |
| result_o | output | 32 | Latched return value |

## Verification
Arguments, target and start are due one edge after a launching trigger. The stored result and the drop of start are due one edge after the end pulse. The done bits are combinational and appear in the same cycle as the end input. The bench drives inputs just after a falling edge and updates a behavioural model on each rising edge. It compares every output at the next falling edge, so registered results are checked one edge after their cause and done bits are checked against the inputs currently applied. A second instance built with a single target runs on the same stimulus to cover the tied-off identifier.

// File: rtl/callout_pkg.sv
// Shared constants and types for the call handshake unit.
// Assumes a fixed six-word argument frame of 32-bit words.
package callout_pkg;
    parameter int ARG_COUNT = 6;
    parameter int DATA_W    = 32;
    parameter int ARG_BUS_W = ARG_COUNT * DATA_W;

    typedef logic [DATA_W-1:0]    word_t;
    typedef logic [ARG_BUS_W-1:0] arg_bus_t;
endpackage

// File: rtl/callout_pick.sv
// Fixed-priority selector: grants the lowest-indexed requesting slot and
// returns its index. Assumes the caller uses the result only when any_o is set.
module callout_pick #(
    parameter int N  = 3,
    parameter int SW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [SW-1:0] sel_o,
    output logic          any_o
);
    // one grant bit per slot, masked by all lower-indexed requests
    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == 0) begin : g_first
            assign grant_o[i] = req_i[i];
        end else begin : g_rest
            assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
        end
    end

    // encode the lowest requesting index (descending scan, last hit wins)
    always_comb begin
        sel_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) sel_o = SW'(i);
        end
    end

    assign any_o = |req_i;

    // grant and encoded index must agree
    always_comb begin
        // R3
        grant_onehot_chk: assert ($onehot0(grant_o));
        // R3
        if (any_o) begin
            grant_sel_chk: assert (grant_o[sel_o] && req_i[sel_o]);
        end
    end
endmodule

// File: rtl/callout_latch.sv
// Argument and target registers: on load, copies the selected slot's six
// words and identifier. Assumes sel_i is below SLOTS whenever load_i is set.
module callout_latch
    import callout_pkg::*;
#(
    parameter int SLOTS   = 3,
    parameter int TARGETS = 4,
    parameter int IDW     = 2,
    parameter int SW      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [SW-1:0]          sel_i,
    input  logic [SLOTS*ARG_BUS_W-1:0] args_i,
    input  logic [SLOTS*IDW-1:0]   ids_i,
    output arg_bus_t               args_o,
    output logic [IDW-1:0]         id_o
);
    // argument frame register
    always_ff @(posedge clk) begin
        if (!rst_n)      args_o <= '0;
        else if (load_i) args_o <= args_i[sel_i*ARG_BUS_W +: ARG_BUS_W];
    end

    if (TARGETS > 1) begin : g_multi
        // identifier register, only when more than one target exists
        always_ff @(posedge clk) begin
            if (!rst_n)      id_o <= '0;
            else if (load_i) id_o <= ids_i[sel_i*IDW +: IDW];
        end
    end else begin : g_single
        logic unused_ids;
        assign unused_ids = ^ids_i;
        assign id_o       = '0;
    end
endmodule

// File: rtl/callout_track.sv
// Pending-call tracker: holds the per-slot strobe, the start request and the
// returned value. Assumes at most one grant bit is set when launch_i is high.
module callout_track
    import callout_pkg::*;
#(
    parameter int SLOTS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic [SLOTS-1:0] grant_i,
    input  logic             end_i,
    input  word_t            result_i,
    output logic [SLOTS-1:0] done_o,
    output logic             start_o,
    output word_t            result_o,
    output logic             busy_o
);
    logic [SLOTS-1:0] strb_q;
    logic             complete;

    assign done_o   = strb_q & {SLOTS{end_i}};
    assign complete = |done_o;
    assign busy_o   = |strb_q;

    // strobe and start: set on launch, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q  <= '0;
            start_o <= 1'b0;
        end else if (complete) begin
            strb_q  <= '0;
            start_o <= 1'b0;
        end else if (launch_i) begin
            strb_q  <= grant_i;
            start_o <= 1'b1;
        end
    end

    // capture the callee's return value at completion
    always_ff @(posedge clk) begin
        if (!rst_n)        result_o <= '0;
        else if (complete) result_o <= result_i;
    end

    // R5
    one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb_q) && $onehot0(done_o));
    // R5
    done_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_i |-> done_o == '0);
    // R6
    start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o && !end_i |=> start_o);
    // R6
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o && end_i |=> !start_o);
    // R8
    result_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> result_o == $past(result_i));
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !complete |=> $stable(result_o));
endmodule

// File: rtl/callout_unit.sv
// Call handshake unit top: arbitrates slot triggers, latches the chosen
// call's arguments and target, drives start until the callee's end pulse and
// reports per-slot completion. Assumes one call in flight at a time.
module callout_unit
    import callout_pkg::*;
#(
    parameter int  NUM_SLOTS   = 3,
    parameter int  NUM_TARGETS = 4,
    localparam int ID_W        = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SLOTS-1:0]           call_trig_i,
    input  logic [NUM_SLOTS*ID_W-1:0]      call_target_i,
    input  logic [NUM_SLOTS*ARG_BUS_W-1:0] call_args_i,
    input  logic                           callee_end_i,
    input  logic [DATA_W-1:0]              callee_result_i,
    output logic [ARG_BUS_W-1:0]           arg_o,
    output logic [ID_W-1:0]                target_o,
    output logic                           start_o,
    output logic [NUM_SLOTS-1:0]           slot_done_o,
    output logic [DATA_W-1:0]              result_o
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [NUM_SLOTS-1:0] grant;
    logic [SLOT_W-1:0]    sel;
    logic                 any_req;
    logic                 busy;
    logic                 launch;

    // launch only from idle
    assign launch = ~busy & any_req;

    callout_pick #(.N(NUM_SLOTS), .SW(SLOT_W)) u_pick (
        .req_i   (call_trig_i),
        .grant_o (grant),
        .sel_o   (sel),
        .any_o   (any_req)
    );

    callout_latch #(
        .SLOTS(NUM_SLOTS), .TARGETS(NUM_TARGETS), .IDW(ID_W), .SW(SLOT_W)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (launch),
        .sel_i  (sel),
        .args_i (call_args_i),
        .ids_i  (call_target_i),
        .args_o (arg_o),
        .id_o   (target_o)
    );

    callout_track #(.SLOTS(NUM_SLOTS)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .grant_i  (grant),
        .end_i    (callee_end_i),
        .result_i (callee_result_i),
        .done_o   (slot_done_o),
        .start_o  (start_o),
        .result_o (result_o),
        .busy_o   (busy)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !start_o && arg_o == '0 && target_o == '0 && result_o == '0);
    // R2
    launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> start_o && arg_o == $past(call_args_i[sel*ARG_BUS_W +: ARG_BUS_W]));
    // R7
    pending_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(arg_o) && $stable(target_o));
endmodule

// File: tb/callout_unit_test.sv
`timescale 1ns/1ps
module callout_unit_test;
    localparam int NS  = 3;
    localparam int NT  = 4;
    localparam int IDW = 2;
    localparam int AW  = 192;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     trig = '0;
    logic [NS*IDW-1:0] ids = '0;
    logic [NS-1:0]     ids1 = '0;
    logic [NS*AW-1:0]  args = '0;
    logic              end_i = 1'b0;
    logic [31:0]       res_i = '0;

    logic [AW-1:0]  arg_o, arg1;
    logic [IDW-1:0] tgt_o;
    logic [0:0]     tgt1;
    logic           start_o, start1;
    logic [NS-1:0]  done_o, done1;
    logic [31:0]    result_o, result1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    callout_unit #(.NUM_SLOTS(NS), .NUM_TARGETS(NT)) uut (
        .clk(clk), .rst_n(rst_n), .call_trig_i(trig), .call_target_i(ids),
        .call_args_i(args), .callee_end_i(end_i), .callee_result_i(res_i),
        .arg_o(arg_o), .target_o(tgt_o), .start_o(start_o),
        .slot_done_o(done_o), .result_o(result_o));

    callout_unit #(.NUM_SLOTS(NS), .NUM_TARGETS(1)) uut1 (
        .clk(clk), .rst_n(rst_n), .call_trig_i(trig), .call_target_i(ids1),
        .call_args_i(args), .callee_end_i(end_i), .callee_result_i(res_i),
        .arg_o(arg1), .target_o(tgt1), .start_o(start1),
        .slot_done_o(done1), .result_o(result1));

    // behavioural reference model
    int            pend = -1;
    logic [AW-1:0] m_arg = '0;
    logic [IDW-1:0] m_tgt = '0;
    bit            m_start = 0;
    logic [31:0]   m_res = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend = -1; m_arg = '0; m_tgt = '0; m_start = 0; m_res = '0;
        end else if (pend >= 0) begin
            if (end_i) begin
                m_res = res_i; pend = -1; m_start = 0;
            end
        end else begin
            for (int s = NS - 1; s >= 0; s--) if (trig[s]) pend = s;
            if (pend >= 0) begin
                m_start = 1;
                m_arg = args[pend*AW +: AW];
                m_tgt = ids[pend*IDW +: IDW];
            end
        end
    end

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every output at the falling edge
    always @(negedge clk) begin
        logic [NS-1:0] exp_done;
        if (!finished) begin
            exp_done = (pend >= 0 && end_i) ? NS'(1 << pend) : '0;
            if (!rst_n) begin
                chk("R1 arg", 256'(arg_o), 256'(0));
                chk("R1 start", 256'(start_o), 256'(0));
                chk("R1 target", 256'(tgt_o), 256'(0));
                chk("R1 result", 256'(result_o), 256'(0));
            end else begin
                chk("R2/R3/R7 arg", 256'(arg_o), 256'(m_arg));
                chk("R4 target", 256'(tgt_o), 256'(m_tgt));
                chk("R6 start", 256'(start_o), 256'(m_start));
                chk("R5 done", 256'(done_o), 256'(exp_done));
                chk("R8 result", 256'(result_o), 256'(m_res));
                chk("R4 single target", 256'(tgt1), 256'(0));
                chk("R6 single start", 256'(start1), 256'(m_start));
                chk("R5 single done", 256'(done1), 256'(exp_done));
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic fill_args();
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < 6; k++)
                args[s*AW + k*32 +: 32] = {8'(s), 8'(k), 16'($urandom)};
        ids = NS*IDW'($urandom);
    endtask

    initial begin
        cyc(3);
        fill_args();
        rst_n = 1'b1;
        cyc(2);
        // R2 R4: single trigger on slot 1
        trig = 3'b010; cyc(1); trig = '0;
        cyc(3);
        // R5 R6 R8: end pulse with a result
        res_i = 32'hCAFE_0001; end_i = 1'b1; cyc(1); end_i = 1'b0;
        cyc(2);
        // R3: two simultaneous triggers, lowest wins
        fill_args(); trig = 3'b110; cyc(1); trig = '0; cyc(1);
        res_i = 32'h1234_5678; end_i = 1'b1; cyc(1); end_i = 1'b0;
        fill_args(); trig = 3'b101; cyc(1); trig = '0; cyc(1);
        // R7: triggers and new args while pending
        fill_args(); trig = 3'b011; cyc(3);
        // R7: trigger in completion cycle is ignored, relaunch after
        res_i = 32'hDEAD_BEEF; end_i = 1'b1; cyc(1); end_i = 1'b0;
        cyc(2); trig = '0;
        res_i = 32'h0BAD_F00D; end_i = 1'b1; cyc(1); end_i = 1'b0;
        // R8: end pulse while idle is ignored
        res_i = 32'h5555_AAAA; end_i = 1'b1; cyc(2); end_i = 1'b0;
        cyc(2);
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            trig  = NS'($urandom);
            end_i = ($urandom % 3) == 0;
            res_i = $urandom;
            if (($urandom % 5) == 0) fill_args();
            cyc(1);
        end
        trig = '0; end_i = 1'b0;
        // R1: reset in the middle of a call
        trig = 3'b100; cyc(1); trig = '0; cyc(1);
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(3);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule